// File: doc/BRIEF.md
# Cascaded Divide-by-25 Counter with Strobes

This block divides its clock by twenty-five. Two 4-bit counter slices share one clock edge. A carry chain joins them: the upper slice moves only when the lower slice rolls over. The pair counts 0 through 24. A synchronous clear then returns it to 0, so the counter passes through 25 states per period.

Two single-cycle strobes mark points in the period. One fires at the terminal value 24 and the other at the midpoint value 12. The terminal test reads only the count bits that are set in 24. This is sound because the count never goes past 24. The midpoint test decodes every bit, so it marks one count and not a run of four. The carry out of the lower slice is also brought out, for chaining or for observation.

An active-low asynchronous reset sets the counter at power-up. A synchronous clear input returns it to 0 on the next clock edge. A count enable gates all advancing.

Top module: `mod25_counter`

## Requirements
- R1: When `en_i` is high, `srst_i` is low and the count is below 24, the count rises by exactly one on each clock edge.
- R2: The count never exceeds 24. During continuous counting the sequence is 0, 1, ..., 24, 0, which is 25 states per period.
- R3: When the count is 24 and `en_i` is high, the count is 0 after the next clock edge. The value 24 lasts exactly one clock during continuous counting.
- R4: `carry_o` is high exactly when `en_i` is high and `count_o[3:0]` equals 15. The upper nibble `count_o[7:4]` changes only on an edge where `carry_o` was high, or on a clear.
- R5: `mid_o` is high exactly when the count equals 12. During continuous counting it is high for one clock in each 25-clock period.
- R6: `term_o` is high exactly when the count equals 24. During continuous counting it is high for one clock in each period.
- R7: When `srst_i` is high, the count is 0 after the next clock edge. This clear takes priority over counting and over the terminal clear.
- R8: When `en_i` is low and `srst_i` is low, the count holds, including at 24. `carry_o` is low, and `term_o` and `mid_o` follow the held value.
- R9: While `rst_ni` is low, the count is 0 and all strobes are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock shared by both slices |
| rst_ni | input | 1 | Asynchronous reset, active low |
| srst_i | input | 1 | Synchronous clear to 0, highest priority |
| en_i | input | 1 | Count enable |
| count_o | output | 8 | Current count value, 0 to 24 |
| term_o | output | 1 | High while the count is 24 |
| mid_o | output | 1 | High while the count is 12 |
| carry_o | output | 1 | Ripple carry from the lower slice |

## Verification
The hardest state to reach is the counter parked at 24 with the enable low. In that state the terminal strobe must stay high and the terminal clear must wait. In free counting, 24 lasts only one clock. The stimulus therefore counts up to 24, drops the enable on the cycle the count arrives, and holds it low for several clocks before enabling again. A synchronous clear is also issued at 24 and at values inside the upper nibble, and a reference counter is compared against all outputs on every cycle.

// File: rtl/mod25_pkg.sv
package mod25_pkg;
  localparam int unsigned SLICE_W  = 4;
  localparam int unsigned N_SLICES = 2;
  localparam int unsigned CNT_W    = SLICE_W * N_SLICES;
  localparam int unsigned TERM_VAL = 24;
  localparam int unsigned MID_VAL  = 12;
  typedef logic [CNT_W-1:0] cnt_t;
endpackage

// File: rtl/mod25_slice.sv
module mod25_slice #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         enp_i,
  input  logic         ent_i,
  output logic [W-1:0] q_o,
  output logic         rco_o
);
  localparam logic [W-1:0] QMAX = '1;

  logic [W-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              q_q <= '0;
    else if (clr_i)           q_q <= '0;
    else if (enp_i && ent_i)  q_q <= q_q + 1'b1;
  end

  assign q_o   = q_q;
  assign rco_o = ent_i & (q_q == QMAX);

  // rollover when the slice is at its maximum and advances
  assert_slice_wrap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rco_o && enp_i && !clr_i) |=> (q_q == '0));
endmodule

// File: rtl/mod25_decode.sv
module mod25_decode #(
  parameter int unsigned W    = 8,
  parameter int unsigned TERM = 24,
  parameter int unsigned MID  = 12
) (
  input  logic [W-1:0] cnt_i,
  output logic         term_o,
  output logic         mid_o
);
  localparam logic [W-1:0] TMASK = TERM[W-1:0];
  localparam logic [W-1:0] MVAL  = MID[W-1:0];

  // partial decode: only bits set in TERM; valid since count never passes TERM
  assign term_o = &(cnt_i | ~TMASK);
  // full decode keeps the strobe one count wide
  assign mid_o  = (cnt_i == MVAL);
endmodule

// File: rtl/mod25_counter.sv
module mod25_counter
  import mod25_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             srst_i,
  input  logic             en_i,
  output logic [CNT_W-1:0] count_o,
  output logic             term_o,
  output logic             mid_o,
  output logic             carry_o
);
  localparam logic [CNT_W-1:0] TERM_C = TERM_VAL[CNT_W-1:0];

  logic [N_SLICES:0] carry;
  logic              clr;
  cnt_t              cnt;
  logic              term;

  assign carry[0] = en_i;
  assign clr      = srst_i | (en_i & term);

  for (genvar k = 0; k < N_SLICES; k++) begin : g_slice
    mod25_slice #(.W(SLICE_W)) u_slice (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .clr_i (clr),
      .enp_i (en_i),
      .ent_i (carry[k]),
      .q_o   (cnt[k*SLICE_W +: SLICE_W]),
      .rco_o (carry[k+1])
    );
  end

  mod25_decode #(.W(CNT_W), .TERM(TERM_VAL), .MID(MID_VAL)) u_dec (
    .cnt_i (cnt),
    .term_o(term),
    .mid_o (mid_o)
  );

  assign count_o = cnt;
  assign term_o  = term;
  assign carry_o = carry[1];

  assert_inc_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !srst_i && !term) |=> (cnt == $past(cnt) + 1'b1));
  assert_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= TERM_C);
  assert_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (term && en_i && !srst_i) |=> (cnt == '0));
  assert_hi_adv_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!carry[1] && !clr) |=> $stable(cnt[CNT_W-1:SLICE_W]));
  assert_mid_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mid_o && en_i) |=> !mid_o);
  assert_srst_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_i |=> (cnt == '0));
  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !srst_i) |=> $stable(cnt));
  assert_carry_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !carry_o);
endmodule

// File: tb/sim_mod25_counter.sv
module sim_mod25_counter;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       srst = 1'b0;
  logic       en = 1'b0;
  logic [7:0] count;
  logic       term, mid, carry;

  int checks = 0;
  int errors = 0;
  int ref_cnt = 0;
  bit done = 1'b0;
  int mids = 0;
  int terms = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mod25_counter u0 (
    .clk_i(clk), .rst_ni(rst_ni), .srst_i(srst), .en_i(en),
    .count_o(count), .term_o(term), .mid_o(mid), .carry_o(carry)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (ref count %0d)", tag, act, exp, ref_cnt);
    end
  endtask

  task automatic check_all(input logic e);
    chk("R2 count", int'(count), ref_cnt);
    chk("R6 term", int'(term), int'(ref_cnt == 24));
    chk("R5 mid", int'(mid), int'(ref_cnt == 12));
    chk("R4 carry", int'(carry), int'(e && (ref_cnt % 16 == 15)));
  endtask

  task automatic step(input logic s, input logic e);
    @(negedge clk);
    srst = s;
    en = e;
    @(posedge clk);
    if (s) ref_cnt = 0;
    else if (e) ref_cnt = (ref_cnt == 24) ? 0 : ref_cnt + 1;
    #1;
    if (mid) mids++;
    if (term) terms++;
    check_all(e);
  endtask

  initial begin
    #(CLK_PERIOD * 3);
    chk("R9 reset count", int'(count), 0);
    chk("R9 reset term", int'(term), 0);
    chk("R9 reset mid", int'(mid), 0);
    @(negedge clk);
    rst_ni = 1'b1;
    #1;
    check_all(1'b0);

    // R1 R2 R3: three full periods of free counting
    for (int i = 0; i < 75; i++) step(1'b0, 1'b1);
    chk("R5 mid once per period", mids, 3);
    chk("R6 term once per period", terms, 3);
    chk("R2 back at zero", int'(count), 0);

    // R8: enable gated on alternate cycles
    for (int i = 0; i < 60; i++) step(1'b0, i % 2 == 0);

    // R8: hold at 24 with enable low, then release (R3)
    while (ref_cnt != 24) step(1'b0, 1'b1);
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0);
    chk("R8 held at 24", int'(count), 24);
    step(1'b0, 1'b1);
    chk("R3 clear after held 24", int'(count), 0);

    // R8: hold at 12 keeps mid high
    while (ref_cnt != 12) step(1'b0, 1'b1);
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0);
    chk("R8 mid held", int'(mid), 1);

    // R7: clear inside the upper nibble while counting
    while (ref_cnt != 17) step(1'b0, 1'b1);
    step(1'b1, 1'b1);
    chk("R7 clear from 17", int'(count), 0);
    // R7: clear at 24 with enable low
    while (ref_cnt != 24) step(1'b0, 1'b1);
    step(1'b1, 1'b0);
    chk("R7 clear from 24 no enable", int'(count), 0);
    // R7: clear at 15 with carry active
    while (ref_cnt != 15) step(1'b0, 1'b1);
    step(1'b1, 1'b1);
    chk("R7 clear beats carry", int'(count), 0);

    for (int i = 0; i < 30; i++) step(1'b0, 1'b1);

    // R9: async reset mid-count
    #2;
    rst_ni = 1'b0;
    #1;
    ref_cnt = 0;
    chk("R9 async reset", int'(count), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule